// File: doc/BRIEF.md
# Serial HDLC Frame Receiver with Maximum Length Enforcement

This block receives one serial HDLC channel. Line bits arrive on `rx_bit` and are taken only in cycles where the bit-clock enable `rx_en` is high. The block hunts for the opening flag, strips the zeros the transmitter inserted after runs of five ones, and recognises closing flags and abort sequences. It assembles the remaining bits into bytes and runs a CRC-16/CCITT check over them. Payload bytes leave on a simple valid strobe, and the two check bytes are held back and never delivered.

A programmable limit `max_len` bounds the byte count of a frame, counted from the byte after the opening flag up to the closing flag, check bytes included. When a frame grows past the limit, delivery stops at once and the rest of that frame is dropped. The frame is still reported when it closes, with its length-error bit set. Every reported frame gives one `done` pulse with four status bits; this pulse plays the part of an interrupt request. Frames shorter than four bytes vanish without trace. A static input, `msb_first`, selects whether the first line bit of each byte is bit 0 or bit 7 of the delivered byte.

Top module: `hdlc_rx_lenlim`

## Requirements
- R1: A frame of N bytes between flags (4 <= N <= `max_len`, N counting the two check bytes) delivers exactly N-2 bytes in line order; only the final one carries `out_last`, and it arrives in the same cycle as `done`.
- R2: A zero that follows five consecutive ones on the line is removed, so payload bytes 0xFF and 0x7E come out unchanged.
- R3: Seven consecutive ones inside a frame abort it. If at least four bytes were received, one `done` pulse follows with `st_abort`=1 and no `out_last`; otherwise nothing is reported. Further bits are ignored until the next flag.
- R4: With `done`, `st_crc_err` is 0 when the CRC-16 register (reflected polynomial 0x8408, preset 0xFFFF, fed with data and check bits) ends at 0xF0B8, and 1 otherwise.
- R5: A frame with fewer than four complete bytes between flags produces no `out_valid` and no `done`.
- R6: When the byte count exceeds `max_len`, no further byte of that frame is delivered (so `max_len`-3 bytes come out for `max_len` >= 4), no `out_last` is given, and the `done` at the closing flag carries `st_len_err`=1.
- R7: A frame whose byte count equals `max_len` is delivered in full with `st_len_err`=0.
- R8: Each reported frame produces exactly one `done` pulse, one cycle wide.
- R9: When the number of bits between flags is not a multiple of eight, `done` carries `st_non_octet`=1; otherwise it is 0.
- R10: With `msb_first`=1, the first line bit of each byte lands in bit 7 of `out_data`; with 0 it lands in bit 0. The CRC always runs in line order.
- R11: Back-to-back flags, and two flags that share one zero, are both accepted as frame boundaries.
- R12: After reset, `out_valid`, `out_last` and `done` are low, and idle all-ones before the first flag reports nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Bit-clock enable; `rx_bit` is taken when high |
| rx_bit | input | 1 | Serial line bit |
| msb_first | input | 1 | 1: first bit of a byte is bit 7 |
| max_len | input | LEN_W | Largest accepted byte count, check bytes included |
| out_valid | output | 1 | `out_data` holds a payload byte |
| out_data | output | 8 | Payload byte |
| out_last | output | 1 | Final byte of a frame |
| done | output | 1 | One-cycle frame-report pulse |
| st_len_err | output | 1 | Frame exceeded `max_len` (valid with `done`) |
| st_crc_err | output | 1 | Check sequence wrong (valid with `done`) |
| st_non_octet | output | 1 | Bit count not a multiple of 8 (valid with `done`) |
| st_abort | output | 1 | Frame ended by abort (valid with `done`) |

## Verification
A sweep sends payloads from zero to twelve bytes against several limits. This separates silent short frames, frames exactly at the limit and frames one or more bytes past it, so an off-by-one in the counter or in the holdback shows up as a wrong byte count. Payloads are built around 0xFF and 0x7E so that zero deletion is exercised in every frame. Single frames then cover a corrupted check field, an abort after five bytes and after two, trailing odd bits, reversed bit order, and flags that are repeated or share their zero, each with a distinct expected status pattern.

// File: rtl/hdlcr_pkg.sv
package hdlcr_pkg;
   typedef struct packed {
      logic len_err;
      logic crc_err;
      logic non_octet;
      logic aborted;
   } rx_status_t;
endpackage

// File: rtl/hdlcr_bitproc.sv
// Line bit processing: zero deletion, flag and abort recognition, and a
// seven-bit delay that keeps the leading bits of a flag out of the frame.
module hdlcr_bitproc (
   input  logic clk,
   input  logic rst_n,
   input  logic rx_en,
   input  logic rx_bit,
   output logic commit_v,
   output logic commit_b,
   output logic flag_ev,
   output logic abort_ev,
   output logic in_frame
);
   localparam int DLY = 7;   // bits of a flag pushed before it is recognised

   logic [2:0]     ones_q, ones_d;
   logic [2:0]     fill_q, fill_d;
   logic [DLY-1:0] dl_q, dl_d;
   logic           hunt_q, hunt_d;
   logic           push;

   always_comb begin
      ones_d   = ones_q;
      fill_d   = fill_q;
      dl_d     = dl_q;
      hunt_d   = hunt_q;
      push     = 1'b0;
      commit_v = 1'b0;
      commit_b = dl_q[DLY-1];
      flag_ev  = 1'b0;
      abort_ev = 1'b0;
      if (rx_en) begin
         if (rx_bit) begin
            if (ones_q != 3'd7) ones_d = ones_q + 3'd1;
            if (ones_q == 3'd6) begin
               abort_ev = !hunt_q;
               hunt_d   = 1'b1;
               fill_d   = '0;
            end else if (ones_q < 3'd6) begin
               push = 1'b1;
            end
         end else begin
            ones_d = '0;
            if (ones_q == 3'd6) begin
               flag_ev = 1'b1;
               hunt_d  = 1'b0;
               fill_d  = '0;
            end else if (ones_q < 3'd5) begin
               push = 1'b1;
            end
         end
         if (push && !hunt_q) begin
            commit_v = (fill_q == 3'(DLY));
            dl_d     = {dl_q[DLY-2:0], rx_bit};
            if (fill_q != 3'(DLY)) fill_d = fill_q + 3'd1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ones_q <= '0;
         fill_q <= '0;
         dl_q   <= '0;
         hunt_q <= 1'b1;
      end else begin
         ones_q <= ones_d;
         fill_q <= fill_d;
         dl_q   <= dl_d;
         hunt_q <= hunt_d;
      end
   end

   assign in_frame = !hunt_q;

   assert_stuffed_dropped_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_en && !rx_bit && ones_q == 3'd5) |-> !commit_v)
      else $error("stuffed zero reached the frame");

   assert_flag_opens_R11: assert property (@(posedge clk) disable iff (!rst_n)
      flag_ev |=> in_frame)
      else $error("flag did not open a frame");

   assert_abort_hunts_R3: assert property (@(posedge clk) disable iff (!rst_n)
      abort_ev |=> !in_frame)
      else $error("abort left the frame open");
endmodule

// File: rtl/hdlcr_crc.sv
// Bit-serial reflected CRC with a residue compare.
module hdlcr_crc #(
   parameter int          W       = 16,
   parameter logic [W-1:0] POLY    = 16'h8408,
   parameter logic [W-1:0] INIT    = 16'hFFFF,
   parameter logic [W-1:0] RESIDUE = 16'hF0B8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic step,
   input  logic bit_in,
   output logic good
);
   if (W < 8 || (W % 8) != 0) begin : g_bad_width
      $error("CRC width must be a whole number of bytes");
   end

   logic [W-1:0] crc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     crc_q <= INIT;
      else if (clear) crc_q <= INIT;
      else if (step)  crc_q <= (crc_q >> 1) ^ ((crc_q[0] ^ bit_in) ? POLY : '0);
   end

   assign good = (crc_q == RESIDUE);

   assert_clear_presets_R4: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> !good)
      else $error("preset value matched the residue");
endmodule

// File: rtl/hdlcr_framer.sv
// Byte assembly, length limit, check-byte holdback and frame reporting.
module hdlcr_framer
   import hdlcr_pkg::*;
#(
   parameter int LEN_W     = 16,
   parameter int CRC_BYTES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             msb_first,
   input  logic [LEN_W-1:0] max_len,
   input  logic             commit_v,
   input  logic             commit_b,
   input  logic             flag_ev,
   input  logic             abort_ev,
   input  logic             in_frame,
   input  logic             crc_good,
   output logic             out_valid,
   output logic [7:0]       out_data,
   output logic             out_last,
   output logic             done,
   output rx_status_t       status
);
   localparam int HOLD      = CRC_BYTES + 1;
   localparam int MIN_BYTES = HOLD + 1;
   localparam int CNT_W     = LEN_W + 1;

   if (LEN_W < 4) begin : g_bad_len
      $error("length field too narrow");
   end
   if (CRC_BYTES < 1) begin : g_bad_crc
      $error("at least one check byte required");
   end

   logic [7:0]        sh_q, sh_n;
   logic [2:0]        bitc_q;
   logic [CNT_W-1:0]  cnt_q, cnt_inc;
   logic [HOLD*8-1:0] hold_q;
   logic              lg_q, over, byte_done, close_rep, abort_rep;
   logic [7:0]        oldest;

   assign sh_n      = msb_first ? {sh_q[6:0], commit_b} : {commit_b, sh_q[7:1]};
   assign byte_done = commit_v && (bitc_q == 3'd7);
   assign cnt_inc   = (cnt_q == '1) ? cnt_q : cnt_q + CNT_W'(1);
   assign over      = cnt_inc > {1'b0, max_len};
   assign close_rep = flag_ev && in_frame && (cnt_q >= CNT_W'(MIN_BYTES));
   assign abort_rep = abort_ev && (cnt_q >= CNT_W'(MIN_BYTES));
   assign oldest    = hold_q[HOLD*8-1 -: 8];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hold_q <= '0;
      else if (byte_done) hold_q <= {hold_q[(HOLD-1)*8-1:0], sh_n};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q      <= '0;
         bitc_q    <= '0;
         cnt_q     <= '0;
         lg_q      <= 1'b0;
         out_valid <= 1'b0;
         out_data  <= '0;
         out_last  <= 1'b0;
         done      <= 1'b0;
         status    <= '0;
      end else begin
         out_valid <= 1'b0;
         out_last  <= 1'b0;
         done      <= 1'b0;
         status    <= '0;
         if (flag_ev || abort_ev) begin
            sh_q   <= '0;
            bitc_q <= '0;
            cnt_q  <= '0;
            lg_q   <= 1'b0;
            if (close_rep) begin
               done   <= 1'b1;
               status <= '{len_err: lg_q, crc_err: !crc_good,
                           non_octet: (bitc_q != 3'd0), aborted: 1'b0};
               if (!lg_q) begin
                  out_valid <= 1'b1;
                  out_last  <= 1'b1;
                  out_data  <= oldest;
               end
            end else if (abort_rep) begin
               done   <= 1'b1;
               status <= '{len_err: lg_q, crc_err: 1'b0, non_octet: 1'b0, aborted: 1'b1};
            end
         end else if (commit_v) begin
            sh_q   <= sh_n;
            bitc_q <= bitc_q + 3'd1;
            if (byte_done) begin
               cnt_q <= cnt_inc;
               lg_q  <= lg_q | over;
               if (cnt_inc > CNT_W'(HOLD) && !(lg_q || over)) begin
                  out_valid <= 1'b1;
                  out_data  <= oldest;
               end
            end
         end
      end
   end

   assert_last_with_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
      out_last |-> (done && out_valid))
      else $error("last byte without frame report");

   assert_no_data_past_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
      lg_q |=> !out_valid)
      else $error("byte delivered after the length limit");

   assert_single_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done)
      else $error("frame report wider than one cycle");

   assert_short_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_ev && cnt_q < CNT_W'(MIN_BYTES)) |=> (!done && !out_valid))
      else $error("short frame was reported");
endmodule

// File: rtl/hdlc_rx_lenlim.sv
module hdlc_rx_lenlim
   import hdlcr_pkg::*;
#(
   parameter int          LEN_W       = 16,
   parameter int          CRC_W       = 16,
   parameter logic [CRC_W-1:0] CRC_POLY    = 16'h8408,
   parameter logic [CRC_W-1:0] CRC_INIT    = 16'hFFFF,
   parameter logic [CRC_W-1:0] CRC_RESIDUE = 16'hF0B8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_en,
   input  logic             rx_bit,
   input  logic             msb_first,
   input  logic [LEN_W-1:0] max_len,
   output logic             out_valid,
   output logic [7:0]       out_data,
   output logic             out_last,
   output logic             done,
   output logic             st_len_err,
   output logic             st_crc_err,
   output logic             st_non_octet,
   output logic             st_abort
);
   localparam int CRC_BYTES = CRC_W / 8;

   logic       commit_v, commit_b, flag_ev, abort_ev, in_frame, crc_good;
   rx_status_t status;

   hdlcr_bitproc u_bits (
      .clk      (clk),
      .rst_n    (rst_n),
      .rx_en    (rx_en),
      .rx_bit   (rx_bit),
      .commit_v (commit_v),
      .commit_b (commit_b),
      .flag_ev  (flag_ev),
      .abort_ev (abort_ev),
      .in_frame (in_frame)
   );

   hdlcr_crc #(
      .W       (CRC_W),
      .POLY    (CRC_POLY),
      .INIT    (CRC_INIT),
      .RESIDUE (CRC_RESIDUE)
   ) u_crc (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (flag_ev | abort_ev),
      .step   (commit_v),
      .bit_in (commit_b),
      .good   (crc_good)
   );

   hdlcr_framer #(
      .LEN_W     (LEN_W),
      .CRC_BYTES (CRC_BYTES)
   ) u_frm (
      .clk       (clk),
      .rst_n     (rst_n),
      .msb_first (msb_first),
      .max_len   (max_len),
      .commit_v  (commit_v),
      .commit_b  (commit_b),
      .flag_ev   (flag_ev),
      .abort_ev  (abort_ev),
      .in_frame  (in_frame),
      .crc_good  (crc_good),
      .out_valid (out_valid),
      .out_data  (out_data),
      .out_last  (out_last),
      .done      (done),
      .status    (status)
   );

   assign st_len_err   = status.len_err;
   assign st_crc_err   = status.crc_err;
   assign st_non_octet = status.non_octet;
   assign st_abort     = status.aborted;

   assert_status_only_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (st_len_err || st_crc_err || st_non_octet || st_abort) |-> done)
      else $error("status bit outside a frame report");
endmodule

// File: tb/hdlc_rx_lenlim_tb.sv
module hdlc_rx_lenlim_tb_top;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rx_en = 1'b0;
   logic        rx_bit = 1'b0;
   logic        msb_first = 1'b0;
   logic [15:0] max_len = 16'hFFFF;
   logic        out_valid, out_last, done;
   logic [7:0]  out_data;
   logic        st_len_err, st_crc_err, st_non_octet, st_abort;

   always #(CLK_PERIOD/2) clk = ~clk;

   hdlc_rx_lenlim dut_i (
      .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rx_bit(rx_bit),
      .msb_first(msb_first), .max_len(max_len),
      .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
      .done(done), .st_len_err(st_len_err), .st_crc_err(st_crc_err),
      .st_non_octet(st_non_octet), .st_abort(st_abort)
   );

   int total = 0;
   int bad = 0;
   int cyc = 0;
   bit finished = 0;

   logic [7:0] cap_d [0:511];
   int         cap_n = 0, last_n = 0, last_pos = -1, done_n = 0;
   logic [3:0] done_st = '0;   // {len, crc, non_octet, abort}

   always @(negedge clk) if (rst_n) begin
      if (out_valid) begin
         if (cap_n < 512) cap_d[cap_n] = out_data;
         if (out_last) begin last_n++; last_pos = cap_n; end
         cap_n++;
      end
      if (done) begin
         done_n++;
         done_st = {st_len_err, st_crc_err, st_non_octet, st_abort};
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !finished) begin
         finished = 1;
         total++; bad++;
         $display("FAIL watchdog: actual=%0d cycles expected<150000", cyc);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   logic [7:0] fb [0:31];
   int fn = 0;
   int ones_tx = 0;

   function automatic logic [15:0] crc_upd(input logic [15:0] c_in, input logic [7:0] v);
      logic [15:0] c;
      logic f;
      c = c_in;
      for (int k = 0; k < 8; k++) begin
         f = c[0] ^ v[k];
         c = c >> 1;
         if (f) c = c ^ 16'h8408;
      end
      return c;
   endfunction

   function automatic logic [7:0] rev8(input logic [7:0] v);
      logic [7:0] r;
      for (int k = 0; k < 8; k++) r[k] = v[7-k];
      return r;
   endfunction

   function automatic logic [7:0] pay(input int i, input int seed);
      int s;
      s = (i + seed) % 5;
      if (s == 0) return 8'hFF;
      if (s == 1) return 8'h7E;
      return 8'((i * 29 + seed * 13 + 3) & 255);
   endfunction

   function automatic int mval(input int mi);
      case (mi)
         0: return 4;
         1: return 5;
         2: return 6;
         3: return 8;
         4: return 11;
         default: return 65535;
      endcase
   endfunction

   task automatic build(input int plen, input int seed);
      logic [15:0] c;
      c = 16'hFFFF;
      for (int i = 0; i < plen; i++) begin
         fb[i] = pay(i, seed);
         c = crc_upd(c, fb[i]);
      end
      c = ~c;
      fb[plen]   = c[7:0];
      fb[plen+1] = c[15:8];
      fn = plen + 2;
   endtask

   task automatic line_bit(input logic b);
      @(negedge clk);
      rx_bit = b;
      rx_en  = 1'b1;
      @(negedge clk);
      rx_en  = 1'b0;
   endtask

   task automatic data_bit(input logic b);
      line_bit(b);
      if (b) begin
         ones_tx++;
         if (ones_tx == 5) begin
            line_bit(1'b0);
            ones_tx = 0;
         end
      end else ones_tx = 0;
   endtask

   task automatic flag();
      for (int i = 0; i < 8; i++) line_bit(i != 0 && i != 7);
      ones_tx = 0;
   endtask

   task automatic send_byte(input logic [7:0] v);
      for (int i = 0; i < 8; i++) data_bit(v[i]);
   endtask

   task automatic idle(input int k);
      repeat (k) @(negedge clk);
   endtask

   task automatic clear_cap();
      @(posedge clk);
      cap_n = 0; last_n = 0; last_pos = -1; done_n = 0; done_st = '0;
   endtask

   task automatic send_body();
      flag();
      for (int i = 0; i < fn; i++) send_byte(fb[i]);
      flag();
      idle(4);
   endtask

   task automatic expect_frame(input int n, input int m, input bit rev, input bit crc_bad);
      int  exp_out;
      bit  over;
      logic [7:0] e;
      if (n < 4) begin
         check(cap_n == 0, "R5 short frame data", cap_n, 0);
         check(done_n == 0, "R5 short frame report", done_n, 0);
      end else begin
         over    = (n > m);
         exp_out = over ? m - 3 : n - 2;
         check(cap_n == exp_out, over ? "R6 byte count past limit" : "R1 byte count",
               cap_n, exp_out);
         for (int i = 0; i < exp_out && i < cap_n; i++) begin
            e = rev ? rev8(fb[i]) : fb[i];
            check(cap_d[i] == e, rev ? "R10 reversed byte" : "R2 destuffed byte",
                  int'(cap_d[i]), int'(e));
         end
         check(last_n == (over ? 0 : 1), "R1 last marker count", last_n, over ? 0 : 1);
         if (!over) check(last_pos == exp_out - 1, "R1 last position", last_pos, exp_out - 1);
         check(done_n == 1, "R8 one report", done_n, 1);
         check(done_st[3] == over, over ? "R6 length error" : "R7 no length error",
               int'(done_st[3]), int'(over));
         if (!over) check(done_st[2] == crc_bad, "R4 crc status", int'(done_st[2]), int'(crc_bad));
         check(done_st[1] == 1'b0, "R9 octet aligned", int'(done_st[1]), 0);
         check(done_st[0] == 1'b0, "R3 no abort", int'(done_st[0]), 0);
      end
   endtask

   initial begin
      idle(3);
      // R12: reset state
      check(out_valid == 1'b0, "R12 valid in reset", int'(out_valid), 0);
      check(done == 1'b0, "R12 done in reset", int'(done), 0);
      @(negedge clk);
      rst_n = 1'b1;
      idle(2);
      check(out_valid == 1'b0 && out_last == 1'b0, "R12 outputs after reset",
            int'(out_valid), 0);

      // R12: idle ones while hunting give no report
      clear_cap();
      for (int i = 0; i < 20; i++) line_bit(1'b1);
      idle(4);
      check(done_n == 0, "R12 idle ones silent", done_n, 0);

      // Sweep of payload length against limits (R1 R2 R4 R5 R6 R7 R8)
      for (int p = 0; p <= 12; p++) begin
         for (int mi = 0; mi < 6; mi++) begin
            build(p, p + mi);
            max_len = 16'(mval(mi));
            clear_cap();
            send_body();
            expect_frame(p + 2, mval(mi), 1'b0, 1'b0);
         end
      end
      max_len = 16'hFFFF;

      // R5: one lone byte
      fb[0] = 8'hA5; fn = 1;
      clear_cap(); send_body();
      expect_frame(1, 65535, 1'b0, 1'b0);

      // R4: corrupted payload byte
      build(6, 3);
      fb[1] = fb[1] ^ 8'h10;
      clear_cap(); send_body();
      expect_frame(8, 65535, 1'b0, 1'b1);

      // R10: reversed bit order
      msb_first = 1'b1;
      build(5, 7);
      clear_cap(); send_body();
      expect_frame(7, 65535, 1'b1, 1'b0);
      msb_first = 1'b0;

      // R3: abort after six bytes sent, five complete in the receiver
      for (int i = 0; i < 6; i++) fb[i] = 8'(8'h31 + i * 8'h11);
      fb[5] = 8'h00;
      clear_cap();
      flag();
      for (int i = 0; i < 6; i++) send_byte(fb[i]);
      for (int i = 0; i < 7; i++) line_bit(1'b1);
      line_bit(1'b0);
      idle(4);
      check(cap_n == 2, "R3 bytes before abort", cap_n, 2);
      if (cap_n >= 2) begin
         check(cap_d[0] == fb[0], "R3 first byte", int'(cap_d[0]), int'(fb[0]));
         check(cap_d[1] == fb[1], "R3 second byte", int'(cap_d[1]), int'(fb[1]));
      end
      check(done_n == 1, "R3 abort report", done_n, 1);
      check(done_st[0] == 1'b1, "R3 abort status", int'(done_st[0]), 1);
      check(last_n == 0, "R3 no last marker", last_n, 0);

      // R3: bits after abort ignored until a flag
      clear_cap();
      for (int i = 0; i < 3; i++) send_byte(8'h55);
      idle(4);
      check(cap_n == 0 && done_n == 0, "R3 hunting ignores bits", cap_n + done_n, 0);

      // R3: short abort is silent
      clear_cap();
      flag();
      send_byte(8'h12); send_byte(8'h00);
      for (int i = 0; i < 7; i++) line_bit(1'b1);
      line_bit(1'b0);
      idle(4);
      check(done_n == 0 && cap_n == 0, "R3 short abort silent", done_n + cap_n, 0);

      // R9: three stray bits before the closing flag
      for (int i = 0; i < 5; i++) fb[i] = 8'(8'h20 + i);
      clear_cap();
      flag();
      for (int i = 0; i < 5; i++) send_byte(fb[i]);
      data_bit(1'b1); data_bit(1'b0); data_bit(1'b1);
      flag();
      idle(4);
      check(cap_n == 3, "R9 bytes delivered", cap_n, 3);
      check(done_n == 1, "R9 report", done_n, 1);
      check(done_st[1] == 1'b1, "R9 non-octet status", int'(done_st[1]), 1);
      check(last_pos == 2, "R9 last position", last_pos, 2);

      // R11: repeated flags, then a shared-zero flag between two frames
      clear_cap();
      flag(); flag(); flag();
      build(3, 1);
      for (int i = 0; i < fn; i++) send_byte(fb[i]);
      flag();
      for (int i = 0; i < 6; i++) line_bit(1'b1);
      line_bit(1'b0);
      ones_tx = 0;
      for (int i = 0; i < 3; i++) cap_d[500 + i] = fb[i];
      build(4, 2);
      for (int i = 0; i < fn; i++) send_byte(fb[i]);
      flag();
      idle(4);
      check(done_n == 2, "R11 two frames reported", done_n, 2);
      check(cap_n == 7, "R11 total bytes", cap_n, 7);
      check(last_n == 2, "R11 last markers", last_n, 2);
      if (cap_n == 7) begin
         for (int i = 0; i < 3; i++)
            check(cap_d[i] == cap_d[500 + i], "R11 first frame byte",
                  int'(cap_d[i]), int'(cap_d[500 + i]));
         for (int i = 0; i < 4; i++)
            check(cap_d[3 + i] == fb[i], "R11 second frame byte",
                  int'(cap_d[3 + i]), int'(fb[i]));
      end
      check(done_st[2] == 1'b0, "R11 second frame crc", int'(done_st[2]), 0);

      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule